// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block is a hardware sequencer that pushes a configuration bitstream into a programmable target device over a byte-wide slave port. After a start strobe that carries a byte count, it pulses the target's program line and waits for the target to report that its init/busy pair has cleared. It then raises write, chip select and the configuration clock, and takes bytes one at a time from a valid/ready source. It puts each byte on the data bus and gives it one full clock pulse.

When busy checking is enabled, a busy indication seen at the end of a pulse causes extra pulses with the same byte on the bus. After the last byte the strobes are released in a fixed order. The sequencer keeps clocking until the target reports done. Each wait phase has its own timeout. The outcome is reported with a one-cycle finish pulse and a two-bit status code.

Top module: `cfg_par_loader`

## Requirements
- R1: On start, `prog_o` is high for exactly HALF_CYC cycles and then low. `wr_o` does not rise while `init_i` and `busy_i` are both high.
- R2: Before any data, `wr_o` rises first, `cs_o` rises on the next cycle, and the configuration clock is high from the cycle after that.
- R3: Each byte appears on `d_o` one cycle before `cclk_o` falls. `cclk_o` then stays low for HALF_CYC cycles and high for HALF_CYC cycles, and `d_o` is stable while `cclk_o` is low with `cs_o` high. Bytes reach the target's rising edges in source order.
- R4: With BUSY_CHK=1, `busy_i` is sampled in the last cycle of each high phase. If it is high, another full pulse is given with the same byte, and this repeats until `busy_i` is low.
- R5: After the last data pulse, `cs_o` falls while `wr_o` is still high, and `wr_o` falls on the following cycle.
- R6: After the release, `done_i` is checked. If it is high, the run ends with status 0. Otherwise one more clock pulse (HALF_CYC low, HALF_CYC high) is given and `done_i` is checked again, so the target sees exactly as many pulses as it needs.
- R7: A wait lasting TIMEOUT_CYC cycles aborts the run. The status is 1 for the init/busy wait, 2 for a busy stall, and 3 for the done phase. On any abort, `cs_o` and `wr_o` are low.
- R8: `fin_o` is high for one cycle per run. `status_o` carries the code from that cycle on and holds it until the next finish.
- R9: A byte count of zero gives no data pulses. The sequencer goes straight from raising the strobes to releasing them and to the done phase.
- R10: `in_ready_o` is high only while the sequencer waits for the next byte with `wr_o`, `cs_o` and `cclk_o` high. Bytes offered at other times are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a load when idle |
| len_i | input | CNT_W | Number of bytes to load |
| in_valid_i | input | 1 | Source byte valid |
| in_data_i | input | DW | Source byte |
| in_ready_o | output | 1 | Byte accepted this cycle when valid |
| prog_o | output | 1 | Program request to target (high = asserted) |
| cs_o | output | 1 | Chip select (high = asserted) |
| wr_o | output | 1 | Write strobe (high = asserted) |
| cclk_o | output | 1 | Configuration clock, idles high |
| d_o | output | DW | Configuration data bus |
| init_i | input | 1 | Target init indication |
| busy_i | input | 1 | Target busy indication |
| done_i | input | 1 | Target done indication |
| fin_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 0 ok, 1 init timeout, 2 busy timeout, 3 done timeout |

## Verification
The bench builds the loader with HALF_CYC=2, TIMEOUT_CYC=64, CNT_W=8 and busy checking enabled. The short half period makes every pulse edge land a few cycles apart, so phase lengths can be measured exactly. The short timeout puts all three abort paths within a few hundred cycles. A target model answers with configurable init hold, busy stalls at a chosen byte and a chosen number of done-phase pulses.

// File: rtl/cfl_pkg.sv
`timescale 1ns/1ps
package cfl_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_PROG, S_WAIT, S_WR, S_CS, S_CK, S_FETCH, S_FALL,
        S_LOW, S_HIGH, S_RCS, S_RWR, S_DCHK, S_DLOW, S_DHIGH
    } state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_INIT_TO = 2'd1,
        ST_BUSY_TO = 2'd2,
        ST_DONE_TO = 2'd3
    } status_e;
endpackage

// File: rtl/cfl_phase.sv
`timescale 1ns/1ps
// Counts cycles inside one timed state; last_o marks its final cycle.
module cfl_phase #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic last_o
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == CW'(HALF_CYC - 1));

    always_comb begin
        if (restart_i)   cnt_d = '0;
        else if (last_o) cnt_d = cnt_q;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfl_tmo.sv
`timescale 1ns/1ps
// Wait-window counter: runs while run_i is high, flags the limit cycle.
module cfl_tmo #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        if (!run_i)         cnt_d = '0;
        else if (expired_o) cnt_d = cnt_q;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfg_par_loader.sv
`timescale 1ns/1ps
module cfg_par_loader #(
    parameter int HALF_CYC    = 4,
    parameter int TIMEOUT_CYC = 100000,
    parameter int CNT_W       = 24,
    parameter int DW          = 8,
    parameter bit BUSY_CHK    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             in_valid_i,
    input  logic [DW-1:0]    in_data_i,
    output logic             in_ready_o,
    output logic             prog_o,
    output logic             cs_o,
    output logic             wr_o,
    output logic             cclk_o,
    output logic [DW-1:0]    d_o,
    input  logic             init_i,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             fin_o,
    output logic [1:0]       status_o
);
    import cfl_pkg::*;

    typedef struct packed {
        state_e           st;
        logic             prog;
        logic             cs;
        logic             wr;
        logic             cclk;
        logic [DW-1:0]    dat;
        logic [CNT_W-1:0] left;
        logic             stall;
        logic             fin;
        status_e          stat;
    } regs_t;

    localparam regs_t RST = '{
        st: S_IDLE, prog: 1'b0, cs: 1'b0, wr: 1'b0, cclk: 1'b1,
        dat: '0, left: '0, stall: 1'b0, fin: 1'b0, stat: ST_OK
    };

    regs_t r_d, r_q;
    logic  ph_last, ph_restart;
    logic  tmo_run, tmo_exp;

    // Timed phases restart whenever the state changes.
    assign ph_restart = (r_d.st != r_q.st);

    always_comb begin
        unique case (r_q.st)
            S_WAIT, S_DCHK, S_DLOW, S_DHIGH: tmo_run = 1'b1;
            S_LOW, S_HIGH:                   tmo_run = r_q.stall;
            default:                         tmo_run = 1'b0;
        endcase
    end

    cfl_phase #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ph_restart),
        .last_o    (ph_last)
    );

    cfl_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmo_run),
        .expired_o (tmo_exp)
    );

    function automatic regs_t finish(regs_t cur, status_e code);
        regs_t n;
        n       = cur;
        n.fin   = 1'b1;
        n.stat  = code;
        n.st    = S_IDLE;
        n.cs    = 1'b0;
        n.wr    = 1'b0;
        n.cclk  = 1'b1;
        n.stall = 1'b0;
        return n;
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.prog = 1'b1;
                    r_d.left = len_i;
                    r_d.st   = S_PROG;
                end
            end
            S_PROG: begin
                if (ph_last) begin
                    r_d.prog = 1'b0;
                    r_d.st   = S_WAIT;
                end
            end
            S_WAIT: begin
                if (!(init_i && busy_i)) r_d.st = S_WR;
                else if (tmo_exp)        r_d = finish(r_q, ST_INIT_TO);
            end
            S_WR: begin
                r_d.wr = 1'b1;
                r_d.st = S_CS;
            end
            S_CS: begin
                r_d.cs = 1'b1;
                r_d.st = S_CK;
            end
            S_CK: begin
                r_d.cclk = 1'b1;
                r_d.st   = (r_q.left == '0) ? S_RCS : S_FETCH;
            end
            S_FETCH: begin
                if (in_valid_i) begin
                    r_d.dat  = in_data_i;
                    r_d.left = r_q.left - 1'b1;
                    r_d.st   = S_FALL;
                end
            end
            S_FALL: begin
                r_d.cclk = 1'b0;
                r_d.st   = S_LOW;
            end
            S_LOW: begin
                if (r_q.stall && tmo_exp) r_d = finish(r_q, ST_BUSY_TO);
                else if (ph_last) begin
                    r_d.cclk = 1'b1;
                    r_d.st   = S_HIGH;
                end
            end
            S_HIGH: begin
                if (r_q.stall && tmo_exp) r_d = finish(r_q, ST_BUSY_TO);
                else if (ph_last) begin
                    if (BUSY_CHK && busy_i) begin
                        r_d.stall = 1'b1;
                        r_d.cclk  = 1'b0;
                        r_d.st    = S_LOW;
                    end else begin
                        r_d.stall = 1'b0;
                        r_d.st    = (r_q.left == '0) ? S_RCS : S_FETCH;
                    end
                end
            end
            S_RCS: begin
                r_d.cs = 1'b0;
                r_d.st = S_RWR;
            end
            S_RWR: begin
                r_d.wr = 1'b0;
                r_d.st = S_DCHK;
            end
            S_DCHK: begin
                if (done_i)       r_d = finish(r_q, ST_OK);
                else if (tmo_exp) r_d = finish(r_q, ST_DONE_TO);
                else begin
                    r_d.cclk = 1'b0;
                    r_d.st   = S_DLOW;
                end
            end
            S_DLOW: begin
                if (tmo_exp) r_d = finish(r_q, ST_DONE_TO);
                else if (ph_last) begin
                    r_d.cclk = 1'b1;
                    r_d.st   = S_DHIGH;
                end
            end
            S_DHIGH: begin
                if (tmo_exp)      r_d = finish(r_q, ST_DONE_TO);
                else if (ph_last) r_d.st = S_DCHK;
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign in_ready_o = (r_q.st == S_FETCH);
    assign prog_o     = r_q.prog;
    assign cs_o       = r_q.cs;
    assign wr_o       = r_q.wr;
    assign cclk_o     = r_q.cclk;
    assign d_o        = r_q.dat;
    assign fin_o      = r_q.fin;
    assign status_o   = r_q.stat;

    // R1
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_o |-> (!cs_o && !wr_o));
    // R2
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> wr_o);
    // R3
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && !cclk_o) |-> $stable(d_o));
    // R5
    cs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_o) |-> !cs_o);
    // R8
    fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);
    // R10
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (cs_o && wr_o && cclk_o));
endmodule

// File: tb/cfg_par_loader_bench.sv
`timescale 1ns/1ps
module cfg_par_loader_bench;
    localparam int HALF = 2;
    localparam int TMO  = 64;
    localparam int CW   = 8;
    localparam int NEVER = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] len_i = '0;
    logic          in_valid_i = 1'b0;
    logic [7:0]    in_data_i = '0;
    logic          in_ready_o, prog_o, cs_o, wr_o, cclk_o, fin_o;
    logic [7:0]    d_o;
    logic [1:0]    status_o;
    logic          init_h = 1'b0;
    logic          busy_st = 1'b0;
    logic          init_i, busy_i, done_i;

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // scenario parameters (written by the main process only)
    int stall_at = -1, stall_n = 0, done_after = 0, exp_stat = 0;
    bit loose = 1'b0, expect_abort = 1'b0;
    logic [7:0] exp_q[$];

    // target model state (written by the monitor only)
    int cap_idx = 0, stall_left = 0, done_cnt = 0;
    int fin_cnt = 0;
    int t_fall = 0;

    assign init_i = init_h;
    assign busy_i = busy_st | init_h;
    assign done_i = (done_cnt >= done_after);

    cfg_par_loader #(
        .HALF_CYC(HALF), .TIMEOUT_CYC(TMO), .CNT_W(CW), .DW(8), .BUSY_CHK(1'b1)
    ) u_cfg_par_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .prog_o(prog_o), .cs_o(cs_o), .wr_o(wr_o), .cclk_o(cclk_o), .d_o(d_o),
        .init_i(init_i), .busy_i(busy_i), .done_i(done_i),
        .fin_o(fin_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 53 + i * 29 + 7) ^ (i << 3));
    endfunction

    // Target model and scoreboard monitor: rising clock edges.
    always @(posedge cclk_o or posedge prog_o) begin
        #1;
        if (prog_o) begin
            cap_idx    = 0;
            stall_left = 0;
            done_cnt   = 0;
            busy_st    = 1'b0;
        end else if (cs_o) begin
            // R3: low phase length
            chk(cyc - t_fall == HALF, "R3 low phase cycles", cyc - t_fall, HALF);
            if (!loose) begin
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected capture", d_o, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    // R3 order, R4 repeated byte during stall
                    chk(d_o == e, "R3/R4 captured byte", d_o, e);
                end
            end
            if (stall_left > 0) begin
                stall_left--;
                if (stall_left == 0) busy_st = 1'b0;
            end else begin
                if (cap_idx == stall_at && stall_n > 0) begin
                    busy_st    = 1'b1;
                    stall_left = stall_n;
                end
                cap_idx++;
            end
        end else begin
            done_cnt++;
        end
    end

    always @(negedge cclk_o) begin
        #1;
        t_fall = cyc;
    end

    // R1: program pulse width
    always @(posedge prog_o) begin
        int tp;
        #1;
        tp = cyc;
        @(negedge prog_o);
        #1;
        chk(cyc - tp == HALF, "R1 program pulse cycles", cyc - tp, HALF);
    end

    // R1, R2: write rises first, and only after init/busy cleared
    always @(posedge wr_o) begin
        #1;
        chk(!cs_o, "R2 cs low when wr rises", cs_o, 0);
        chk(!(init_i && busy_i), "R1 wr rose during init/busy", 1, 0);
        @(posedge clk);
        #1;
        chk(cs_o, "R2 cs one cycle after wr", cs_o, 1);
    end

    // R5: release order
    always @(negedge cs_o) begin
        #1;
        if (!expect_abort) begin
            chk(wr_o, "R5 wr held when cs falls", wr_o, 1);
            @(posedge clk);
            #1;
            chk(!wr_o, "R5 wr falls next cycle", wr_o, 0);
        end
    end

    // Finish monitor: status and scoreboard drain
    always @(negedge clk) begin
        if (fin_o) begin
            chk(status_o == 2'(exp_stat), "R6/R7 status code", status_o, exp_stat);
            if (!loose) chk(exp_q.size() == 0, "R3/R9 bytes left over", exp_q.size(), 0);
            if (exp_stat == 0) chk(done_cnt == done_after, "R6 done pulses", done_cnt, done_after);
            if (expect_abort) chk(!cs_o && !wr_o, "R7 strobes released", {cs_o, wr_o}, 0);
            fin_cnt++;
        end
    end

    task automatic run(input int seed, input int len, input int st_at, input int st_n,
                       input int dn, input int hold, input int est);
        int base, idx, guard;
        stall_at     = st_at;
        stall_n      = st_n;
        done_after   = dn;
        exp_stat     = est;
        expect_abort = (est != 0);
        loose        = (est == 2);
        exp_q.delete();
        if (est != 1) begin
            for (int i = 0; i < len; i++) begin
                exp_q.push_back(pat(seed, i));
                if (i == st_at && st_n > 0 && !loose)
                    for (int k = 0; k < st_n; k++) exp_q.push_back(pat(seed, i));
            end
        end
        base = fin_cnt;
        idx = 0;
        guard = 0;
        @(negedge clk);
        init_h  = (hold > 0);
        start_i = 1'b1;
        len_i   = CW'(len);
        @(negedge clk);
        start_i = 1'b0;
        while (fin_cnt == base && guard < 20000) begin
            if (hold > 0) begin
                // R10: bytes offered during the init wait are not taken
                chk(!in_ready_o, "R10 ready during init wait", in_ready_o, 0);
                hold--;
                if (hold == 0) init_h = 1'b0;
            end
            in_valid_i = (idx < len);
            in_data_i  = pat(seed, idx);
            if (in_valid_i && in_ready_o) idx++;
            @(negedge clk);
            guard++;
        end
        in_valid_i = 1'b0;
        init_h     = 1'b0;
        chk(fin_cnt == base + 1, "R8 one finish per run", fin_cnt - base, 1);
        if (est == 1) chk(idx == 0, "R10 no byte taken before strobes", idx, 0);
        @(negedge clk);
        chk(!fin_o, "R8 finish pulse one cycle", fin_o, 0);
        chk(status_o == 2'(est), "R8 status held", status_o, est);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!prog_o && !cs_o && !wr_o, "reset strobes low", {prog_o, cs_o, wr_o}, 0);
        chk(!fin_o && !in_ready_o, "reset fin/ready low", {fin_o, in_ready_o}, 0);
        chk(cclk_o && status_o == 2'd0, "reset clock high, status 0", {cclk_o, status_o}, 4);

        run(1, 4, -1, 0, 3, 0, 0);        // R3 R5 R6 plain load
        run(2, 6, 2, 3, 0, 10, 0);        // R1 R4 R10 init hold and busy stall
        run(3, 0, -1, 0, 2, 0, 0);        // R9 empty load
        run(4, 3, -1, 0, 1, NEVER, 1);    // R7 init/busy timeout
        run(5, 5, 1, 1000, 0, 0, 2);      // R7 busy timeout
        run(6, 2, -1, 0, NEVER, 0, 3);    // R7 done timeout
        run(7, 5, 0, 1, 4, 3, 0);         // R4 stall on first byte after aborts

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule